// File: doc/BRIEF.md
# Byte Register File with Pair Access

This block is the register storage of a small 8-bit datapath. It holds an accumulator, six general byte registers, a dedicated 16-bit stack pointer and a five-bit flag register. Software-visible byte registers are chosen by a 3-bit code. Two combinational byte read ports and one clocked byte write port serve the ALU path.

Three 16-bit pairs are formed from the general registers. A fourth pair code reaches the stack pointer. A pair can be read, written, incremented or decremented, which is how a memory pointer is stepped. The accumulator and the flags together form a 16-bit status word that can be read and written as a unit. Flags are also loaded from an external ALU result.

All writes take effect at the rising clock edge. Reads are combinational and show the stored state. Code 110 names a memory operand, so the block only reports it and does not store it.

Top module: `byte_regfile`

## Requirements
- R1: After reset every byte register, the stack pointer and all flags read as zero.
- R2: Byte codes select B=000, C=001, D=010, E=011, H=100, L=101 and the accumulator=111. A byte written through the write port is returned by either read port at its code from the next cycle on, and the two read ports select independently.
- R3: Pair codes 00, 01 and 10 select BC, DE and HL. The first-named register is bits 15..8 of the pair. A pair read reflects the byte registers, and a pair write changes exactly those two bytes.
- R4: Pair code 11 selects a 16-bit stack pointer that shares no storage with any byte register or the accumulator.
- R5: A step of the selected pair adds one when the direction input is 0 and subtracts one when it is 1. The step wraps modulo 2^16 and leaves every flag unchanged.
- R6: A byte read with code 110 returns zero and raises that port's memory-reference output. A byte write with code 110 changes no register.
- R7: A pair write or pair step wins over a byte write to the same register in the same cycle. A pair write wins over a step of the same pair. A byte write to another register still happens in that cycle.
- R8: A flag load takes the 5-bit ALU flag input, ordered from bit 4 down as S, Z, AC, P and C, into the flag register.
- R9: The status word read has the accumulator in bits 15..8 and S in bit 7, Z in bit 6, AC in bit 4, P in bit 2 and C in bit 0. Bits 5, 3 and 1 read as zero.
- R10: A status word write loads the accumulator from bits 15..8 and the flags from the bit positions of R9, ignoring bits 5, 3 and 1. It wins over a byte write to the accumulator and over a flag load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_sel | input | 3 | Byte code for read port A |
| rd_a_data | output | 8 | Read port A data |
| rd_a_mem | output | 1 | Read port A named the memory operand |
| rd_b_sel | input | 3 | Byte code for read port B |
| rd_b_data | output | 8 | Read port B data |
| rd_b_mem | output | 1 | Read port B named the memory operand |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 3 | Byte write code |
| wr_data | input | 8 | Byte write data |
| pr_sel | input | 2 | Pair code for read, write and step |
| pr_rd_data | output | 16 | Selected pair value |
| pr_wr_en | input | 1 | Pair write enable |
| pr_wr_data | input | 16 | Pair write data |
| pr_step_en | input | 1 | Pair step enable |
| pr_step_dn | input | 1 | Step direction, 1 is decrement |
| flag_ld_en | input | 1 | Load flags from ALU |
| flag_in | input | 5 | ALU flags {S,Z,AC,P,C} |
| psw_rd_data | output | 16 | Status word |
| psw_wr_en | input | 1 | Status word write enable |
| psw_wr_data | input | 16 | Status word write data |

## Verification
The bench steps HL across 0xFFFF in both directions and decrements the stack pointer from zero. A design without modulo wrap, or with flags touched by the step, shows a wrong pair value or a changed status byte. Same-cycle collisions are driven on purpose: a byte and a pair write to H, a write and a step of DE, and a status word write against an accumulator write and a flag load. A wrong priority leaves the losing value in the register. Code 110 is written and then every byte is read back, which exposes a design that stores the memory code into a neighbour. Byte-pair aliasing is checked from both sides, so a high/low swap in a pair also shows up.

// File: rtl/rf_pkg.sv
package rf_pkg;

   localparam logic [2:0] CODE_MEM = 3'b110;
   localparam logic [2:0] CODE_ACC = 3'b111;
   localparam logic [1:0] PAIR_STK = 2'b11;
   localparam int unsigned N_PAIRS = 3;
   localparam int unsigned N_GEN   = 2 * N_PAIRS;
   localparam int unsigned FLAG_BYTE_W = 8;

   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic c;
   } flags_t;

   function automatic logic [FLAG_BYTE_W-1:0] flags_to_byte(input flags_t f);
      return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b0, f.c};
   endfunction

   function automatic flags_t flags_from_byte(input logic [FLAG_BYTE_W-1:0] b);
      flags_t f;
      f.s  = b[7];
      f.z  = b[6];
      f.ac = b[4];
      f.p  = b[2];
      f.c  = b[0];
      return f;
   endfunction

endpackage

// File: rtl/rf_byte_bank.sv
module rf_byte_bank
   import rf_pkg::*;
#(
   parameter int unsigned DW = 8,
   localparam int unsigned PW = 2 * DW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            wr_sel,
   input  logic [DW-1:0]         wr_data,
   input  logic                  pr_upd_en,
   input  logic [1:0]            pr_idx,
   input  logic [PW-1:0]         pr_val,
   input  logic                  acc_ld_en,
   input  logic [DW-1:0]         acc_ld_val,
   output logic [N_GEN*DW-1:0]   gen_q,
   output logic [DW-1:0]         acc_q
);

   for (genvar i = 0; i < N_GEN; i++) begin : g_reg
      localparam int unsigned PAIR_OF = i / 2;
      localparam bit          IS_HIGH = (i % 2) == 0;
      logic [DW-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (pr_upd_en && (pr_idx == 2'(PAIR_OF))) begin
            q <= IS_HIGH ? pr_val[PW-1:DW] : pr_val[DW-1:0];
         end else if (wr_en && (wr_sel == 3'(i))) begin
            q <= wr_data;
         end
      end

      assign gen_q[i*DW +: DW] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (acc_ld_en) begin
         acc_q <= acc_ld_val;
      end else if (wr_en && (wr_sel == CODE_ACC)) begin
         acc_q <= wr_data;
      end
   end

endmodule

// File: rtl/rf_stack_ptr.sv
module rf_stack_ptr #(
   parameter int unsigned        AW      = 16,
   parameter logic [AW-1:0]      RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_val,
   input  logic          step_en,
   input  logic          step_dn,
   output logic [AW-1:0] sp_q
);

   logic [AW-1:0] stepped;

   assign stepped = step_dn ? (sp_q - AW'(1)) : (sp_q + AW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= RST_VAL;
      end else if (ld_en) begin
         sp_q <= ld_val;
      end else if (step_en) begin
         sp_q <= stepped;
      end
   end

endmodule

// File: rtl/rf_flag_reg.sv
module rf_flag_reg
   import rf_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   alu_ld_en,
   input  flags_t alu_flags,
   input  logic   psw_ld_en,
   input  flags_t psw_flags,
   output flags_t flags_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (psw_ld_en) begin
         flags_q <= psw_flags;
      end else if (alu_ld_en) begin
         flags_q <= alu_flags;
      end
   end

endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
   import rf_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic [2:0]          sel,
   input  logic [N_GEN*DW-1:0] gen_q,
   input  logic [DW-1:0]       acc_q,
   output logic [DW-1:0]       data,
   output logic                mem_ref
);

   always_comb begin
      mem_ref = 1'b0;
      data    = '0;
      unique case (sel)
         CODE_ACC: data = acc_q;
         CODE_MEM: mem_ref = 1'b1;
         default:  data = gen_q[int'(sel)*DW +: DW];
      endcase
   end

endmodule

// File: rtl/byte_regfile.sv
module byte_regfile
   import rf_pkg::*;
#(
   parameter int unsigned     DW        = 8,
   parameter logic [2*DW-1:0] SP_RESET  = '0,
   localparam int unsigned    PW        = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    rd_a_sel,
   output logic [DW-1:0] rd_a_data,
   output logic          rd_a_mem,
   input  logic [2:0]    rd_b_sel,
   output logic [DW-1:0] rd_b_data,
   output logic          rd_b_mem,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic [1:0]    pr_sel,
   output logic [PW-1:0] pr_rd_data,
   input  logic          pr_wr_en,
   input  logic [PW-1:0] pr_wr_data,
   input  logic          pr_step_en,
   input  logic          pr_step_dn,
   input  logic          flag_ld_en,
   input  logic [4:0]    flag_in,
   output logic [PW-1:0] psw_rd_data,
   input  logic          psw_wr_en,
   input  logic [PW-1:0] psw_wr_data
);

   if (DW < FLAG_BYTE_W) begin : g_dw_check
      $error("byte_regfile: DW must be at least the flag byte width");
   end

   logic [N_GEN*DW-1:0] gen_q;
   logic [DW-1:0]       acc_q;
   logic [PW-1:0]       sp_q;
   flags_t              flags_q;
   logic [PW-1:0]       pair_cur;
   logic [PW-1:0]       pair_next;
   logic                is_stk;
   logic                gen_pair_upd;

   assign is_stk = (pr_sel == PAIR_STK);

   always_comb begin
      if (is_stk) begin
         pair_cur = sp_q;
      end else begin
         pair_cur = {gen_q[(2*int'(pr_sel))*DW +: DW],
                     gen_q[(2*int'(pr_sel)+1)*DW +: DW]};
      end
   end

   assign pair_next    = pr_wr_en ? pr_wr_data
                       : (pr_step_dn ? (pair_cur - PW'(1)) : (pair_cur + PW'(1)));
   assign gen_pair_upd = (pr_wr_en || pr_step_en) && !is_stk;

   rf_byte_bank #(.DW(DW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .pr_upd_en  (gen_pair_upd),
      .pr_idx     (pr_sel),
      .pr_val     (pair_next),
      .acc_ld_en  (psw_wr_en),
      .acc_ld_val (psw_wr_data[PW-1:DW]),
      .gen_q      (gen_q),
      .acc_q      (acc_q)
   );

   rf_stack_ptr #(.AW(PW), .RST_VAL(SP_RESET)) u_sp (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (pr_wr_en && is_stk),
      .ld_val  (pr_wr_data),
      .step_en (pr_step_en && is_stk),
      .step_dn (pr_step_dn),
      .sp_q    (sp_q)
   );

   rf_flag_reg u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .alu_ld_en (flag_ld_en),
      .alu_flags (flags_t'(flag_in)),
      .psw_ld_en (psw_wr_en),
      .psw_flags (flags_from_byte(psw_wr_data[FLAG_BYTE_W-1:0])),
      .flags_q   (flags_q)
   );

   rf_read_mux #(.DW(DW)) u_rd_a (
      .sel     (rd_a_sel),
      .gen_q   (gen_q),
      .acc_q   (acc_q),
      .data    (rd_a_data),
      .mem_ref (rd_a_mem)
   );

   rf_read_mux #(.DW(DW)) u_rd_b (
      .sel     (rd_b_sel),
      .gen_q   (gen_q),
      .acc_q   (acc_q),
      .data    (rd_b_data),
      .mem_ref (rd_b_mem)
   );

   assign pr_rd_data  = pair_cur;
   assign psw_rd_data = {acc_q, DW'(flags_to_byte(flags_q))};

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int unsigned DW = 8,
   localparam int unsigned PW = 2 * DW
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      rd_a_sel,
   input logic [DW-1:0]   rd_a_data,
   input logic            rd_a_mem,
   input logic            wr_en,
   input logic [2:0]      wr_sel,
   input logic [1:0]      pr_sel,
   input logic            pr_wr_en,
   input logic [PW-1:0]   pr_wr_data,
   input logic            pr_step_en,
   input logic            pr_step_dn,
   input logic            flag_ld_en,
   input logic            psw_wr_en,
   input logic [PW-1:0]   psw_rd_data,
   input logic [6*DW-1:0] gen_q,
   input logic [DW-1:0]   acc_q,
   input logic [PW-1:0]   sp_q,
   input logic [4:0]      flags_q
);

   // R6: memory code reads zero and flags the reference
   a_r6_mem_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_sel == 3'b110) |-> (rd_a_data == '0) && rd_a_mem);

   // R6: a write to the memory code leaves all bytes alone
   a_r6_mem_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == 3'b110) && !pr_wr_en && !pr_step_en && !psw_wr_en)
      |=> ($stable(gen_q) && $stable(acc_q)));

   // R5: steps never touch flags
   a_r5_step_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_step_en && !flag_ld_en && !psw_wr_en) |=> $stable(flags_q));

   // R5: stack pointer increments modulo 2^16
   a_r5_sp_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_step_en && !pr_wr_en && (pr_sel == 2'b11) && !pr_step_dn)
      |=> (sp_q == PW'($past(sp_q) + PW'(1))));

   // R4: stack pointer writes do not alias byte storage
   a_r4_sp_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_wr_en && (pr_sel == 2'b11) && !wr_en && !psw_wr_en)
      |=> ($stable(gen_q) && $stable(acc_q)));

   // R7: HL pair write lands regardless of a same-cycle byte write
   a_r7_pair_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_wr_en && (pr_sel == 2'b10))
      |=> ({gen_q[4*DW +: DW], gen_q[5*DW +: DW]} == $past(pr_wr_data)));

   // R9: unused status bits read zero
   a_r9_psw_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (psw_rd_data[5] == 1'b0) && (psw_rd_data[3] == 1'b0) && (psw_rd_data[1] == 1'b0));

endmodule

bind byte_regfile rf_checker #(.DW(DW)) u_rf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_a_sel    (rd_a_sel),
   .rd_a_data   (rd_a_data),
   .rd_a_mem    (rd_a_mem),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .pr_sel      (pr_sel),
   .pr_wr_en    (pr_wr_en),
   .pr_wr_data  (pr_wr_data),
   .pr_step_en  (pr_step_en),
   .pr_step_dn  (pr_step_dn),
   .flag_ld_en  (flag_ld_en),
   .psw_wr_en   (psw_wr_en),
   .psw_rd_data (psw_rd_data),
   .gen_q       (gen_q),
   .acc_q       (acc_q),
   .sp_q        (sp_q),
   .flags_q     (flags_q)
);

// File: tb/byte_regfile_bench.sv
`timescale 1ns/1ps
module byte_regfile_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
   logic [7:0]  rd_a_data, rd_b_data, wr_data = '0;
   logic        rd_a_mem, rd_b_mem;
   logic        wr_en = 1'b0;
   logic [1:0]  pr_sel = '0;
   logic [15:0] pr_rd_data, pr_wr_data = '0, psw_rd_data, psw_wr_data = '0;
   logic        pr_wr_en = 1'b0, pr_step_en = 1'b0, pr_step_dn = 1'b0;
   logic        flag_ld_en = 1'b0, psw_wr_en = 1'b0;
   logic [4:0]  flag_in = '0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   byte_regfile u_byte_regfile (
      .clk(clk), .rst_n(rst_n),
      .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data), .rd_a_mem(rd_a_mem),
      .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data), .rd_b_mem(rd_b_mem),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pr_sel(pr_sel), .pr_rd_data(pr_rd_data), .pr_wr_en(pr_wr_en),
      .pr_wr_data(pr_wr_data), .pr_step_en(pr_step_en), .pr_step_dn(pr_step_dn),
      .flag_ld_en(flag_ld_en), .flag_in(flag_in),
      .psw_rd_data(psw_rd_data), .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int code);
      return 8'h3C ^ 8'(code * 8'h21);
   endfunction

   task automatic wbyte(input logic [2:0] s, input logic [7:0] v);
      wr_en = 1'b1; wr_sel = s; wr_data = v;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic wpair(input logic [1:0] s, input logic [15:0] v);
      pr_wr_en = 1'b1; pr_sel = s; pr_wr_data = v;
      tick();
      pr_wr_en = 1'b0;
   endtask

   task automatic step(input logic [1:0] s, input logic dn);
      pr_step_en = 1'b1; pr_sel = s; pr_step_dn = dn;
      tick();
      pr_step_en = 1'b0;
   endtask

   task automatic rd_a(input logic [2:0] s, output logic [7:0] v);
      rd_a_sel = s; #0.5; v = rd_a_data;
   endtask

   task automatic rd_pair(input logic [1:0] s, output logic [15:0] v);
      pr_sel = s; #0.5; v = pr_rd_data;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      for (int p = 0; p < 4; p++) begin
         rd_pair(2'(p), v);
         chk("R1 pair after reset", v, 16'h0000);
      end
      chk("R1 status after reset", psw_rd_data, 16'h0000);
   endtask

   task automatic t_bytes();
      logic [7:0] v;
      for (int c = 0; c < 8; c++) if (c != 6) wbyte(3'(c), pat(c));
      for (int c = 0; c < 8; c++) begin
         if (c == 6) continue;
         rd_a(3'(c), v);
         chk("R2 port A byte", {8'h00, v}, {8'h00, pat(c)});
         rd_b_sel = 3'(7 - c == 6 ? 7 : 7 - c); #0.5;
         chk("R2 port B byte", {8'h00, rd_b_data}, {8'h00, pat(7 - c == 6 ? 7 : 7 - c)});
      end
   endtask

   task automatic t_pairs();
      logic [15:0] v;
      logic [7:0]  b;
      rd_pair(2'b00, v); chk("R3 BC read", v, {pat(0), pat(1)});
      rd_pair(2'b01, v); chk("R3 DE read", v, {pat(2), pat(3)});
      wpair(2'b10, 16'hBEEF);
      rd_a(3'b100, b); chk("R3 H from pair", {8'h00, b}, 16'h00BE);
      rd_a(3'b101, b); chk("R3 L from pair", {8'h00, b}, 16'h00EF);
      wpair(2'b11, 16'h1234);
      rd_pair(2'b11, v); chk("R4 SP read", v, 16'h1234);
      rd_pair(2'b00, v); chk("R4 BC untouched by SP", v, {pat(0), pat(1)});
      rd_pair(2'b10, v); chk("R4 HL untouched by SP", v, 16'hBEEF);
      rd_a(3'b111, b); chk("R4 A untouched by SP", {8'h00, b}, {8'h00, pat(7)});
   endtask

   task automatic t_step();
      logic [15:0] v;
      flag_ld_en = 1'b1; flag_in = 5'b10101;
      tick();
      flag_ld_en = 1'b0;
      wpair(2'b10, 16'hFFFF);
      step(2'b10, 1'b0);
      rd_pair(2'b10, v); chk("R5 HL inc wrap", v, 16'h0000);
      step(2'b10, 1'b1);
      rd_pair(2'b10, v); chk("R5 HL dec wrap", v, 16'hFFFF);
      step(2'b10, 1'b1);
      rd_pair(2'b10, v); chk("R5 HL dec", v, 16'hFFFE);
      wpair(2'b11, 16'h0000);
      step(2'b11, 1'b1);
      rd_pair(2'b11, v); chk("R5 SP dec wrap", v, 16'hFFFF);
      step(2'b11, 1'b0);
      rd_pair(2'b11, v); chk("R5 SP inc wrap", v, 16'h0000);
      chk("R5 flags unchanged by steps", {8'h00, psw_rd_data[7:0]}, 16'h0091);
   endtask

   task automatic t_mem();
      logic [7:0] v;
      rd_a_sel = 3'b110; rd_b_sel = 3'b110; #0.5;
      chk("R6 port A mem data", {8'h00, rd_a_data}, 16'h0000);
      chk("R6 port A mem flag", {15'd0, rd_a_mem}, 16'h0001);
      chk("R6 port B mem flag", {15'd0, rd_b_mem}, 16'h0001);
      rd_a_sel = 3'b000; #0.5;
      chk("R6 mem flag low otherwise", {15'd0, rd_a_mem}, 16'h0000);
      for (int c = 0; c < 8; c++) if (c != 6) wbyte(3'(c), 8'(c + 1));
      wbyte(3'b110, 8'h55);
      for (int c = 0; c < 8; c++) begin
         if (c == 6) continue;
         rd_a(3'(c), v);
         chk("R6 mem write ignored", {8'h00, v}, 16'(c + 1));
      end
   endtask

   task automatic t_prio();
      logic [15:0] v;
      logic [7:0]  b;
      wr_en = 1'b1; wr_sel = 3'b100; wr_data = 8'h11;
      pr_wr_en = 1'b1; pr_sel = 2'b10; pr_wr_data = 16'h2233;
      tick();
      wr_en = 1'b0; pr_wr_en = 1'b0;
      rd_pair(2'b10, v); chk("R7 pair beats byte", v, 16'h2233);
      wr_en = 1'b1; wr_sel = 3'b010; wr_data = 8'h77;
      pr_wr_en = 1'b1; pr_sel = 2'b10; pr_wr_data = 16'h4455;
      tick();
      wr_en = 1'b0; pr_wr_en = 1'b0;
      rd_a(3'b010, b); chk("R7 other byte still written", {8'h00, b}, 16'h0077);
      rd_pair(2'b10, v); chk("R7 pair written alongside", v, 16'h4455);
      wr_en = 1'b1; wr_sel = 3'b101; wr_data = 8'h99;
      pr_step_en = 1'b1; pr_step_dn = 1'b0; pr_sel = 2'b10;
      tick();
      wr_en = 1'b0; pr_step_en = 1'b0;
      rd_pair(2'b10, v); chk("R7 step beats byte", v, 16'h4456);
      pr_wr_en = 1'b1; pr_step_en = 1'b1; pr_step_dn = 1'b0;
      pr_sel = 2'b01; pr_wr_data = 16'h4242;
      tick();
      pr_wr_en = 1'b0; pr_step_en = 1'b0;
      rd_pair(2'b01, v); chk("R7 write beats step", v, 16'h4242);
   endtask

   task automatic t_flags();
      logic [4:0] ins [5] = '{5'b11111, 5'b00001, 5'b01000, 5'b00010, 5'b00100};
      logic [7:0] exp [5] = '{8'hD5, 8'h01, 8'h40, 8'h04, 8'h10};
      for (int i = 0; i < 5; i++) begin
         flag_ld_en = 1'b1; flag_in = ins[i];
         tick();
         flag_ld_en = 1'b0;
         chk("R8 R9 flag load to status byte", {8'h00, psw_rd_data[7:0]}, {8'h00, exp[i]});
      end
   endtask

   task automatic t_psw();
      logic [7:0] b;
      psw_wr_en = 1'b1; psw_wr_data = 16'hA5FF;
      tick();
      psw_wr_en = 1'b0;
      chk("R10 R9 status write and read", psw_rd_data, 16'hA5D5);
      rd_a(3'b111, b); chk("R10 accumulator from status", {8'h00, b}, 16'h00A5);
      psw_wr_en = 1'b1; psw_wr_data = 16'h3C00;
      wr_en = 1'b1; wr_sel = 3'b111; wr_data = 8'h99;
      flag_ld_en = 1'b1; flag_in = 5'b11111;
      tick();
      psw_wr_en = 1'b0; wr_en = 1'b0; flag_ld_en = 1'b0;
      chk("R10 status write priority", psw_rd_data, 16'h3C00);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_bytes();
      t_pairs();
      t_step();
      t_mem();
      t_prio();
      t_flags();
      t_psw();
      summary();
      $finish;
   end

endmodule